// File: doc/BRIEF.md
# DAC Output Word Register

This block sits on a host I/O bus and holds the output code for one digital-to-analog converter channel. The host writes the code as two bytes, low and high, or as one 16-bit word. Both bytes go first into staging registers. The converter's output code register changes only when a write includes the high byte. At that write the staged word, merged with any bytes in the same transaction, is committed and a one-cycle update strobe goes to the converter.

A static mode input picks how the code is aligned. In full 16-bit mode the word passes through unchanged. In 12-bit legacy mode the upper twelve bits are kept and the low nibble is forced to zero. An output-configuration input, such as a range selection, is captured into its own register at each commit and never between commits. Reset sets the output to the zero-volt code and clears both staging bytes.

Top module: `dac_word_latch`

## Requirements
- R1: A write cycle (`wr_en` high) at byte address `addr` writes lane 0 (`wdata[7:0]`, enabled by `byte_en[0]`) to byte address `addr` and lane 1 (`wdata[15:8]`, enabled by `byte_en[1]`) to byte address `addr`+1. Byte address 4 is the low data byte and byte address 5 is the high data byte.
- R2: A write that reaches only the low data byte updates the low staging byte and leaves `dac_code`, `dac_cfg` and `dac_update` unchanged.
- R3: Every write that reaches the high data byte commits: `dac_code` takes the aligned word and `dac_update` is high in the following cycle.
- R4: A write to the high data byte alone commits the word {new high byte, low staging byte currently held}.
- R5: A 16-bit write at address 4 with both byte enables commits `wdata` as one word and gives exactly one update pulse.
- R6: `dac_cfg` takes the value of `out_cfg` only at a commit. A change on `out_cfg` between commits leaves `dac_cfg` and `dac_code` unchanged.
- R7: Reset (`rst_n` low) sets `dac_code` to the zero-volt code (default 16'h0000), `dac_cfg` to 0 and `dac_update` to 0, and clears both staging bytes.
- R8: With `mode_full16` = 1 the committed code equals the 16-bit staged word. With `mode_full16` = 0 the block uses 12-bit legacy alignment. The mode is sampled at the commit.
- R9: In 12-bit legacy mode the committed code is {word[15:4], 4'b0000}.
- R10: Cycles with `wr_en` low, and writes whose enabled lanes reach neither address 4 nor address 5, leave all outputs and both staging bytes unchanged.
- R11: `dac_update` is high for exactly one cycle per commit. `dac_code` does not change in any cycle in which `dac_update` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write cycle qualifier |
| addr | input | ADDR_W (4) | Byte address of lane 0 |
| byte_en | input | 2 | Lane enables; bit 0 for wdata[7:0], bit 1 for wdata[15:8] |
| wdata | input | 16 | Write data |
| mode_full16 | input | 1 | 1: full 16-bit code, 0: 12-bit legacy alignment |
| out_cfg | input | CFG_W (2) | Output configuration, captured at commit |
| dac_code | output | 16 | Committed converter code |
| dac_cfg | output | CFG_W (2) | Committed output configuration |
| dac_update | output | 1 | One-cycle strobe after each commit |

## Verification
The bound checker watches, on every cycle, that the code and configuration stay put unless a strobe is present. It also checks that every strobe follows a write that reached the high byte and that every such write produces a strobe. Further cycle-level checks cover the configuration captured at each strobe, zero low nibbles in legacy mode, and a 16-bit write landing verbatim. Only the bench's scenarios can show that the held low byte from an earlier, separate transaction ends up in a later high-only commit. The same goes for cross-lane addressing through an odd base address, and for reset clearing staging so that a later commit carries zero in the low byte.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 2;
    localparam int WORD_W = BYTE_W * LANES;
    localparam int LEGACY_BITS = 12;
    localparam int PAD_BITS    = WORD_W - LEGACY_BITS;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } stage_t;

    // Full mode passes the word; legacy keeps the top bits and zero-fills the rest.
    function automatic logic [WORD_W-1:0] align_code(input logic [WORD_W-1:0] word,
                                                     input logic               full16);
        logic [WORD_W-1:0] res;
        if (full16) begin
            res = word;
        end else begin
            res = {word[WORD_W-1:PAD_BITS], {PAD_BITS{1'b0}}};
        end
        return res;
    endfunction

endpackage

// File: rtl/dacw_decode.sv
module dacw_decode
    import dacw_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LO_OFS = 4
) (
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        byte_en,
    input  logic [WORD_W-1:0]       wdata,
    output logic                    lo_wr,
    output logic                    hi_wr,
    output logic [BYTE_W-1:0]       lo_byte,
    output logic [BYTE_W-1:0]       hi_byte
);

    // One spare bit so addr + lane never wraps back onto a register.
    localparam int            TW   = ADDR_W + 1;
    localparam logic [TW-1:0] LO_T = TW'(LO_OFS);
    localparam logic [TW-1:0] HI_T = TW'(LO_OFS + 1);

    logic [TW-1:0]    tgt [LANES];
    logic [LANES-1:0] lane_lo;
    logic [LANES-1:0] lane_hi;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign tgt[g]     = {1'b0, addr} + TW'(g);
        assign lane_lo[g] = wr_en & byte_en[g] & (tgt[g] == LO_T);
        assign lane_hi[g] = wr_en & byte_en[g] & (tgt[g] == HI_T);
    end

    always_comb begin
        lo_byte = '0;
        hi_byte = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_lo[i]) lo_byte = wdata[i*BYTE_W +: BYTE_W];
            if (lane_hi[i]) hi_byte = wdata[i*BYTE_W +: BYTE_W];
        end
        lo_wr = |lane_lo;
        hi_wr = |lane_hi;
    end

endmodule

// File: rtl/dacw_stage.sv
module dacw_stage
    import dacw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [BYTE_W-1:0] lo_byte,
    input  logic [BYTE_W-1:0] hi_byte,
    output logic              commit,
    output logic [WORD_W-1:0] word
);

    stage_t stage_d;
    stage_t stage_q;

    always_comb begin
        stage_d = stage_q;
        if (lo_wr) stage_d.lo = lo_byte;
        if (hi_wr) stage_d.hi = hi_byte;
        // Word as it stands after this transaction; bytes not written come from staging.
        word   = {stage_d.hi, stage_d.lo};
        commit = hi_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

endmodule

// File: rtl/dacw_commit.sv
module dacw_commit
    import dacw_pkg::*;
#(
    parameter int                CFG_W     = 2,
    parameter logic [WORD_W-1:0] ZERO_CODE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [WORD_W-1:0] word,
    input  logic              full16,
    input  logic [CFG_W-1:0]  cfg_in,
    output logic [WORD_W-1:0] code,
    output logic [CFG_W-1:0]  cfg,
    output logic              upd
);

    typedef struct packed {
        logic [WORD_W-1:0] code;
        logic [CFG_W-1:0]  cfg;
        logic              upd;
    } out_t;

    out_t out_d;
    out_t out_q;

    always_comb begin
        out_d     = out_q;
        out_d.upd = 1'b0;
        if (commit) begin
            out_d.code = align_code(word, full16);
            out_d.cfg  = cfg_in;
            out_d.upd  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.code <= ZERO_CODE;
            out_q.cfg  <= '0;
            out_q.upd  <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign code = out_q.code;
    assign cfg  = out_q.cfg;
    assign upd  = out_q.upd;

endmodule

// File: rtl/dac_word_latch.sv
module dac_word_latch
    import dacw_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter int                LO_OFS    = 4,
    parameter int                CFG_W     = 2,
    parameter logic [WORD_W-1:0] ZERO_CODE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  byte_en,
    input  logic [WORD_W-1:0] wdata,
    input  logic              mode_full16,
    input  logic [CFG_W-1:0]  out_cfg,
    output logic [WORD_W-1:0] dac_code,
    output logic [CFG_W-1:0]  dac_cfg,
    output logic              dac_update
);

    logic              lo_wr;
    logic              hi_wr;
    logic [BYTE_W-1:0] lo_byte;
    logic [BYTE_W-1:0] hi_byte;
    logic              commit;
    logic [WORD_W-1:0] word;

    dacw_decode #(
        .ADDR_W (ADDR_W),
        .LO_OFS (LO_OFS)
    ) u_decode (
        .wr_en   (wr_en),
        .addr    (addr),
        .byte_en (byte_en),
        .wdata   (wdata),
        .lo_wr   (lo_wr),
        .hi_wr   (hi_wr),
        .lo_byte (lo_byte),
        .hi_byte (hi_byte)
    );

    dacw_stage u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo_wr   (lo_wr),
        .hi_wr   (hi_wr),
        .lo_byte (lo_byte),
        .hi_byte (hi_byte),
        .commit  (commit),
        .word    (word)
    );

    dacw_commit #(
        .CFG_W     (CFG_W),
        .ZERO_CODE (ZERO_CODE)
    ) u_commit (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .word   (word),
        .full16 (mode_full16),
        .cfg_in (out_cfg),
        .code   (dac_code),
        .cfg    (dac_cfg),
        .upd    (dac_update)
    );

endmodule

// File: rtl/dac_word_latch_chk.sv
module dac_word_latch_chk
    import dacw_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LO_OFS = 4,
    parameter int CFG_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [LANES-1:0]  byte_en,
    input logic [WORD_W-1:0] wdata,
    input logic              mode_full16,
    input logic [CFG_W-1:0]  out_cfg,
    input logic [WORD_W-1:0] dac_code,
    input logic [CFG_W-1:0]  dac_cfg,
    input logic              dac_update
);

    localparam int            TW   = ADDR_W + 1;
    localparam logic [TW-1:0] HI_A = TW'(LO_OFS + 1);

    logic       bus_hits_hi;
    logic       bus_full_word;
    logic [TW-1:0] a_ext;

    assign a_ext         = {1'b0, addr};
    assign bus_hits_hi   = wr_en && ((byte_en[0] && a_ext == HI_A) ||
                                     (byte_en[1] && a_ext + TW'(1) == HI_A));
    assign bus_full_word = wr_en && (byte_en == 2'b11) && (a_ext == TW'(LO_OFS));

    AST_HIGH_WRITE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hits_hi |=> dac_update); // R3

    AST_STROBE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        dac_update |-> $past(bus_hits_hi)); // R11

    AST_QUIET_HOLDS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_update |-> ($stable(dac_code) && $stable(dac_cfg))); // R6

    AST_CFG_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        dac_update |-> (dac_cfg == $past(out_cfg))); // R6

    AST_LEGACY_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_update && !$past(mode_full16)) |-> (dac_code[3:0] == 4'h0)); // R9

    AST_WORD_LANDS_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_update && $past(mode_full16) && $past(bus_full_word))
            |-> (dac_code == $past(wdata))); // R5

endmodule

bind dac_word_latch dac_word_latch_chk #(
    .ADDR_W (ADDR_W),
    .LO_OFS (LO_OFS),
    .CFG_W  (CFG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .byte_en     (byte_en),
    .wdata       (wdata),
    .mode_full16 (mode_full16),
    .out_cfg     (out_cfg),
    .dac_code    (dac_code),
    .dac_cfg     (dac_cfg),
    .dac_update  (dac_update)
);

// File: tb/tb_dac_word_latch.sv
`timescale 1ns/1ps
module tb_dac_word_latch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [1:0]  byte_en = '0;
    logic [15:0] wdata = '0;
    logic        mode_full16 = 1'b1;
    logic [1:0]  out_cfg = '0;
    logic [15:0] dac_code;
    logic [1:0]  dac_cfg;
    logic        dac_update;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [15:0] exp_code_q [$];
    logic [1:0]  exp_cfg_q [$];
    string       exp_tag_q [$];

    logic [7:0] m_lo = 8'h00;
    logic [7:0] m_hi = 8'h00;

    always #4 clk = ~clk;

    dac_word_latch dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr        (addr),
        .byte_en     (byte_en),
        .wdata       (wdata),
        .mode_full16 (mode_full16),
        .out_cfg     (out_cfg),
        .dac_code    (dac_code),
        .dac_cfg     (dac_cfg),
        .dac_update  (dac_update)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: every strobe seen must match the next expected commit.
    always @(negedge clk) begin
        if (rst_n && dac_update && !finished) begin
            if (exp_code_q.size() == 0) begin
                check(1'b0, "R3 unexpected strobe", dac_code, 16'h0);
            end else begin
                automatic logic [15:0] ec = exp_code_q.pop_front();
                automatic logic [1:0]  ef = exp_cfg_q.pop_front();
                automatic string       et = exp_tag_q.pop_front();
                check(dac_code == ec, {et, " code"}, dac_code, ec);
                check(dac_cfg == ef, {et, " cfg"}, {14'h0, dac_cfg}, {14'h0, ef});
            end
        end
    end

    // Driver: one bus write, model update, expected item pushed on commit.
    task automatic bus_write(input logic [3:0] a, input logic [1:0] be, input logic [15:0] d, input string tag);
        bit hi_hit = 1'b0;
        @(negedge clk);
        wr_en = 1'b1; addr = a; byte_en = be; wdata = d;
        for (int l = 0; l < 2; l++) begin
            automatic int t = int'(a) + l;
            if (be[l] && t == 4) m_lo = d[l*8 +: 8];
            if (be[l] && t == 5) begin m_hi = d[l*8 +: 8]; hi_hit = 1'b1; end
        end
        if (hi_hit) begin
            exp_code_q.push_back(mode_full16 ? {m_hi, m_lo} : {m_hi, m_lo[7:4], 4'h0});
            exp_cfg_q.push_back(out_cfg);
            exp_tag_q.push_back(tag);
        end
        @(negedge clk);
        wr_en = 1'b0; byte_en = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        check(dac_code == 16'h0000, "R7 reset code", dac_code, 16'h0000);
        check(dac_cfg == 2'd0, "R7 reset cfg", {14'h0, dac_cfg}, 16'h0);
        check(dac_update == 1'b0, "R7 reset strobe", {15'h0, dac_update}, 16'h0);
        @(negedge clk); rst_n = 1'b1;
        idle(2);

        mode_full16 = 1'b1; out_cfg = 2'd2;
        // R2: low byte only
        bus_write(4'd4, 2'b01, 16'h00AB, "R2");
        check(dac_code == 16'h0000, "R2 low-only no change", dac_code, 16'h0000);
        check(dac_update == 1'b0, "R2 low-only no strobe", {15'h0, dac_update}, 16'h0);

        // R4 / R1: high byte alone at address 5 commits with held low
        bus_write(4'd5, 2'b01, 16'h0012, "R4 high-alone");
        check(dac_update == 1'b1, "R3 strobe after high write", {15'h0, dac_update}, 16'h1);
        @(negedge clk);
        check(dac_update == 1'b0, "R11 strobe one cycle", {15'h0, dac_update}, 16'h0);
        check(dac_code == 16'h12AB, "R11 code held after strobe", dac_code, 16'h12AB);

        // R6: configuration change between commits
        out_cfg = 2'd1;
        idle(3);
        check(dac_cfg == 2'd2, "R6 cfg not applied early", {14'h0, dac_cfg}, 16'h2);
        check(dac_code == 16'h12AB, "R6 code unchanged", dac_code, 16'h12AB);

        // R5: full 16-bit write
        bus_write(4'd4, 2'b11, 16'hBEEF, "R5 word write");
        idle(2);

        // R10: ignored writes
        bus_write(4'd6, 2'b01, 16'h0099, "R10");
        bus_write(4'd5, 2'b10, 16'h7700, "R10");
        bus_write(4'd2, 2'b11, 16'h5566, "R10");
        bus_write(4'd15, 2'b10, 16'h4400, "R10");
        idle(2);
        check(dac_code == 16'hBEEF, "R10 ignored writes", dac_code, 16'hBEEF);

        // R1: lane 1 reaches the low byte through base address 3
        bus_write(4'd3, 2'b10, 16'h3400, "R1");
        bus_write(4'd5, 2'b01, 16'h0056, "R1 cross-lane low then high");
        idle(2);

        // R8 / R9: legacy mode alignment
        mode_full16 = 1'b0; out_cfg = 2'd3;
        bus_write(4'd4, 2'b11, 16'hABCD, "R9 legacy");
        bus_write(4'd4, 2'b11, 16'hFFFF, "R8 legacy all ones");
        mode_full16 = 1'b1;
        bus_write(4'd5, 2'b01, 16'h00FF, "R8 back to full");
        idle(2);

        // R7: reset clears staging
        bus_write(4'd4, 2'b01, 16'h0077, "R7");
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        check(dac_code == 16'h0000, "R7 mid reset code", dac_code, 16'h0000);
        check(dac_cfg == 2'd0, "R7 mid reset cfg", {14'h0, dac_cfg}, 16'h0);
        @(negedge clk); rst_n = 1'b1;
        m_lo = 8'h00; m_hi = 8'h00;
        idle(1);
        out_cfg = 2'd0;
        bus_write(4'd5, 2'b01, 16'h0001, "R7 staging cleared");
        idle(3);

        check(exp_code_q.size() == 0, "R3 missing strobes", 16'(exp_code_q.size()), 16'h0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule